// File: doc/BRIEF.md
# Multi-PLL GPU Core Clock Selector

This block produces a GPU core clock from three free-running source clocks: two general PLLs and a USB PLL. It builds six derived paths: the first PLL divided by two and by three, the second PLL undivided, divided by three and divided by four, and the USB PLL undivided. A 3-bit selection code picks one path. The code is a bank bit placed above a 2-bit source field. The bank bit changes how the source field is read. Two codes in the upper bank are reserved. When either of them is applied, an error flag is raised and the output stays low.

The selection inputs come from a register outside this block and may change at any time with respect to any source clock. Each path has its own synchronizer and its own gate, both clocked by that path's divided clock. When the selection changes, the path that was driving is first closed in its low phase, in its own domain. Only after that closure has been seen does the new path open, and it opens in its own low phase. No edge is ever shorter than the half-periods of the clocks involved.

Top module: `clksel_top`

## Requirements
- R1: Selection code = {bank_sel, src_sel}. Code 0 (bank 0, field 0) drives core_clk at the first PLL frequency divided by two, with 50 % duty.
- R2: Code 1 (bank 0, field 1) drives core_clk at the first PLL frequency divided by three. The high phase lasts 1.5 source periods (50 % duty).
- R3: Code 2 (bank 0, field 2) drives the second PLL undivided. Code 3 (bank 0, field 3) drives the second PLL divided by three, with a high phase of 1.5 source periods.
- R4: Code 4 (bank 1, field 0) drives the second PLL divided by four, with 50 % duty. Code 5 (bank 1, field 1) drives the USB PLL undivided.
- R5: Codes 6 and 7 (bank 1, field 2 or 3) are reserved. For these codes sel_err is 1, no path is opened, and core_clk stays low with no rising edge once the previous path has closed. For codes 0 to 5, sel_err is 0.
- R6: On any change of code, no high or low pulse on core_clk is shorter than the smaller of the output half-periods of the old and new paths. A path opens only after every other path has closed.
- R7: While rst_n is low, every gate is closed and core_clk is low. Asserting rst_n in the middle of operation forces core_clk low at once.
- R8: At any time, at most one path is gated through to core_clk.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous active-low reset for all dividers and gates |
| pll1_clk | input | 1 | First PLL clock |
| pll2_clk | input | 1 | Second PLL clock |
| usb_clk | input | 1 | USB PLL clock |
| bank_sel | input | 1 | Bank bit; selects how src_sel is decoded |
| src_sel | input | 2 | Source field within the bank |
| core_clk | output | 1 | Selected, divided, glitch-free clock |
| sel_err | output | 1 | High while a reserved code is applied |

## Verification
The closing of the old path and the opening of the new one can fall within the same output period. At that moment both gate registers act on core_clk in the same window. The bench provokes this by sweeping every ordered pair of the eight codes, reserved codes included, on three mutually unrelated source periods. It records the shortest high or low pulse seen around each switch and compares it with the smaller half-period of the two paths, computed from the source periods. After each switch it measures the period and high time of the new clock. When the new code is reserved, it instead confirms that core_clk shows no rising edge at all.

// File: rtl/clksel_pkg.sv
package clksel_pkg;

   localparam int NUM_PATHS = 6;
   localparam int CODE_W    = 3;

   typedef logic [CODE_W-1:0] code_t;

   typedef enum logic [1:0] {
      SRC_PLL1 = 2'd0,
      SRC_PLL2 = 2'd1,
      SRC_USB  = 2'd2
   } src_e;

   // Path index equals the selection code {bank, field}; codes at or above
   // NUM_PATHS have no path.
   function automatic src_e path_source(input int p);
      case (p)
         0, 1:    return SRC_PLL1;
         2, 3, 4: return SRC_PLL2;
         default: return SRC_USB;
      endcase
   endfunction

endpackage

// File: rtl/clksel_div.sv
module clksel_div #(
   parameter int DIV = 2
) (
   input  logic clk_in,
   input  logic rst_n,
   output logic clk_out
);

   if (DIV < 1) begin : g_bad_div
      $error("clksel_div: DIV must be at least 1");
   end

   if (DIV == 1) begin : g_pass
      assign clk_out = clk_in;
   end else begin : g_count
      localparam int            CW     = $clog2(DIV);
      localparam logic [CW-1:0] LAST   = CW'(DIV - 1);
      localparam logic [CW-1:0] HALF_N = CW'(DIV / 2);

      logic [CW-1:0] cnt_q;
      logic [CW-1:0] cnt_nxt;
      logic          hi_q;

      assign cnt_nxt = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;

      always_ff @(posedge clk_in or negedge rst_n) begin
         if (!rst_n) begin
            cnt_q <= '0;
            hi_q  <= 1'b0;
         end else begin
            cnt_q <= cnt_nxt;
            hi_q  <= (cnt_nxt < HALF_N);
         end
      end

      if ((DIV % 2) == 0) begin : g_even
         assign clk_out = hi_q;
      end else begin : g_odd
         // A copy delayed by half an input period stretches the high phase
         // to DIV/2 input periods.
         logic lag_q;
         always_ff @(negedge clk_in or negedge rst_n) begin
            if (!rst_n) lag_q <= 1'b0;
            else        lag_q <= hi_q;
         end
         assign clk_out = hi_q | lag_q;
      end
   end

endmodule

// File: rtl/clksel_gate.sv
module clksel_gate #(
   parameter int SYNC_STAGES = 2
) (
   input  logic path_clk,
   input  logic rst_n,
   input  logic req,
   input  logic others_on,
   output logic gate_on,
   output logic clk_out
);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("clksel_gate: SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] sync_q;

   // The request only passes when no other path is open.
   always_ff @(posedge path_clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '0;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], req & ~others_on};
   end

   // Open and close only while the path clock is low.
   always_ff @(negedge path_clk or negedge rst_n) begin
      if (!rst_n) gate_on <= 1'b0;
      else        gate_on <= sync_q[SYNC_STAGES-1];
   end

   assign clk_out = path_clk & gate_on;

endmodule

// File: rtl/clksel_top.sv
module clksel_top #(
   parameter int DIV_P1_FAST = 2,
   parameter int DIV_P1_SLOW = 3,
   parameter int DIV_P2_MID  = 3,
   parameter int DIV_P2_SLOW = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic       rst_n,
   input  logic       pll1_clk,
   input  logic       pll2_clk,
   input  logic       usb_clk,
   input  logic       bank_sel,
   input  logic [1:0] src_sel,
   output logic       core_clk,
   output logic       sel_err
);

   import clksel_pkg::*;

   localparam int DIV_TAB [NUM_PATHS] =
      '{DIV_P1_FAST, DIV_P1_SLOW, 1, DIV_P2_MID, DIV_P2_SLOW, 1};

   code_t                code;
   logic [NUM_PATHS-1:0] root_clk;
   logic [NUM_PATHS-1:0] path_clk;
   logic [NUM_PATHS-1:0] gate_en;
   logic [NUM_PATHS-1:0] gated_clk;

   assign code    = {bank_sel, src_sel};
   assign sel_err = (code >= CODE_W'(NUM_PATHS));

   for (genvar p = 0; p < NUM_PATHS; p++) begin : g_path
      localparam src_e SRC = path_source(p);
      localparam logic [NUM_PATHS-1:0] SELF = NUM_PATHS'(1) << p;

      logic others_on;
      logic req;

      if (SRC == SRC_PLL1) begin : g_root_p1
         assign root_clk[p] = pll1_clk;
      end else if (SRC == SRC_PLL2) begin : g_root_p2
         assign root_clk[p] = pll2_clk;
      end else begin : g_root_usb
         assign root_clk[p] = usb_clk;
      end

      assign req       = (code == CODE_W'(p));
      assign others_on = |(gate_en & ~SELF);

      clksel_div #(
         .DIV (DIV_TAB[p])
      ) div_i (
         .clk_in  (root_clk[p]),
         .rst_n   (rst_n),
         .clk_out (path_clk[p])
      );

      clksel_gate #(
         .SYNC_STAGES (SYNC_STAGES)
      ) gate_i (
         .path_clk  (path_clk[p]),
         .rst_n     (rst_n),
         .req       (req),
         .others_on (others_on),
         .gate_on   (gate_en[p]),
         .clk_out   (gated_clk[p])
      );
   end

   assign core_clk = |gated_clk;

endmodule

// File: rtl/clksel_chk.sv
module clksel_chk (
   input logic                             rst_n,
   input logic                             ref_clk,
   input logic [clksel_pkg::NUM_PATHS-1:0] path_clk,
   input logic [clksel_pkg::NUM_PATHS-1:0] gate_en,
   input logic [clksel_pkg::CODE_W-1:0]    code,
   input logic                             sel_err
);

   import clksel_pkg::*;

   // R8: never two paths open together
   assert_single_path_R8: assert property (@(posedge ref_clk) disable iff (!rst_n)
      $onehot0(gate_en));

   // R5: a held reserved code opens nothing
   assert_reserved_quiet_R5: assert property (@(posedge ref_clk) disable iff (!rst_n)
      (sel_err && $past(sel_err)) |-> !$rose(|gate_en));

   for (genvar p = 0; p < NUM_PATHS; p++) begin : g_chk
      localparam logic [NUM_PATHS-1:0] SELF = NUM_PATHS'(1) << p;

      // R6: a path opens only once all others are closed
      assert_break_before_make_R6: assert property (@(negedge path_clk[p]) disable iff (!rst_n)
         $rose(gate_en[p]) |-> ((gate_en & ~SELF) == '0));

      // R1: the path that opens is the one the code names
      assert_open_matches_code_R1: assert property (@(negedge path_clk[p]) disable iff (!rst_n)
         $rose(gate_en[p]) |-> (code == CODE_W'(p)));
   end

endmodule

bind clksel_top clksel_chk chk_i (
   .rst_n    (rst_n),
   .ref_clk  (pll2_clk),
   .path_clk (path_clk),
   .gate_en  (gate_en),
   .code     (code),
   .sel_err  (sel_err)
);

// File: tb/clksel_top_tb.sv
`timescale 1ns/1ps
module clksel_top_tb_top;

   localparam real H1 = 5.0;   // first PLL half period (100 MHz)
   localparam real H2 = 3.2;   // second PLL half period
   localparam real HU = 8.3;   // USB PLL half period
   localparam real TOL = 0.02;

   logic       rst_n    = 1'b0;
   logic       pll1_clk = 1'b0;
   logic       pll2_clk = 1'b0;
   logic       usb_clk  = 1'b0;
   logic       bank_sel = 1'b0;
   logic [1:0] src_sel  = 2'd0;
   logic       core_clk;
   logic       sel_err;

   int checks   = 0;
   int failures = 0;
   bit done     = 1'b0;

   always #(H1) pll1_clk = ~pll1_clk;
   always #(H2) pll2_clk = ~pll2_clk;
   always #(HU) usb_clk  = ~usb_clk;

   clksel_top dut_i (
      .rst_n    (rst_n),
      .pll1_clk (pll1_clk),
      .pll2_clk (pll2_clk),
      .usb_clk  (usb_clk),
      .bank_sel (bank_sel),
      .src_sel  (src_sel),
      .core_clk (core_clk),
      .sel_err  (sel_err)
   );

   // Edge measurement on the output
   real t_rise = 0.0, t_fall = 0.0, last_period = 0.0, last_high = 0.0;
   real min_pulse = 1.0e9;
   bit  have_rise = 1'b0, have_fall = 1'b0;
   int  rises = 0;

   always @(posedge core_clk) begin
      if (have_rise) last_period = $realtime - t_rise;
      if (have_fall && ($realtime - t_fall) < min_pulse) min_pulse = $realtime - t_fall;
      t_rise    = $realtime;
      have_rise = 1'b1;
      rises++;
   end

   always @(negedge core_clk) begin
      if (have_rise) begin
         last_high = $realtime - t_rise;
         if (last_high < min_pulse) min_pulse = last_high;
      end
      t_fall    = $realtime;
      have_fall = 1'b1;
   end

   function automatic real exp_period(input int c);
      case (c)
         0: return 4.0 * H1;
         1: return 6.0 * H1;
         2: return 2.0 * H2;
         3: return 6.0 * H2;
         4: return 8.0 * H2;
         5: return 2.0 * HU;
         default: return 0.0;
      endcase
   endfunction

   function automatic string req_of(input int c);
      case (c)
         0: return "R1";
         1: return "R2";
         2, 3: return "R3";
         4: return "R4";
         5: return "R4";
         default: return "R5";
      endcase
   endfunction

   function automatic bit near(input real a, input real b);
      return (a - b < TOL) && (b - a < TOL);
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input real act, input real exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0.3f expected=%0.3f", req, what, act, exp);
      end
   endtask

   task automatic set_code(input int c);
      bank_sel = c[2];
      src_sel  = c[1:0];
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      #500000.0;
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      #0.7;
      set_code(0);
      rises = 0;
      #200.0;
      // R7: nothing toggles while held in reset
      chk(rises == 0, "R7", "rises during reset", real'(rises), 0.0);
      chk(core_clk == 1'b0, "R7", "core_clk in reset", real'(core_clk), 0.0);
      rst_n = 1'b1;
      #600.0;
      chk(near(last_period, exp_period(0)), "R1", "period after reset", last_period, exp_period(0));

      // Sweep all ordered pairs of codes
      for (int a = 0; a < 8; a++) begin
         for (int b = 0; b < 8; b++) begin
            if (a != b) begin
               real lim;
               set_code(a);
               #600.0;
               min_pulse = 1.0e9;
               rises = 0;
               set_code(b);
               #600.0;
               if (a < 6 && b < 6)
                  lim = (exp_period(a) < exp_period(b) ? exp_period(a) : exp_period(b)) / 2.0;
               else if (a < 6)
                  lim = exp_period(a) / 2.0;
               else if (b < 6)
                  lim = exp_period(b) / 2.0;
               else
                  lim = 0.0;
               if (lim > 0.0)
                  chk(min_pulse > lim - TOL, "R6", $sformatf("shortest pulse %0d->%0d", a, b),
                      min_pulse, lim);
               else
                  chk(rises == 0, "R5", $sformatf("edges on reserved switch %0d->%0d", a, b),
                      real'(rises), 0.0);
               chk(sel_err == (b >= 6), "R5", $sformatf("sel_err for code %0d", b),
                   real'(sel_err), real'(b >= 6));
               rises = 0;
               #300.0;
               if (b < 6) begin
                  // R8: an overlap of two paths would distort period or high time
                  chk(near(last_period, exp_period(b)), req_of(b),
                      $sformatf("period code %0d after %0d (R8)", b, a),
                      last_period, exp_period(b));
                  chk(near(last_high, exp_period(b) / 2.0), req_of(b),
                      $sformatf("high time code %0d after %0d", b, a),
                      last_high, exp_period(b) / 2.0);
               end else begin
                  chk(rises == 0, req_of(b), $sformatf("edges with reserved code %0d", b),
                      real'(rises), 0.0);
                  chk(core_clk == 1'b0, req_of(b), $sformatf("level with reserved code %0d", b),
                      real'(core_clk), 0.0);
               end
            end
         end
      end

      // R7: reset in mid-operation forces the output low at once
      set_code(2);
      #600.0;
      rst_n = 1'b0;
      #0.1;
      chk(core_clk == 1'b0, "R7", "core_clk right after reset", real'(core_clk), 0.0);
      rises = 0;
      #100.0;
      chk(rises == 0, "R7", "rises during mid-run reset", real'(rises), 0.0);
      rst_n = 1'b1;
      #600.0;
      chk(near(last_period, exp_period(2)), "R3", "period after second reset",
          last_period, exp_period(2));

      finish_run();
   end

endmodule